// File: doc/BRIEF.md
# GCR Eight-to-Five Stream Decoder

This block sits behind a floppy read channel that has already recovered bit cells, found sync and framed a sector. It receives one 8-bit group-coded byte at a time and turns the stream into plain data bytes. Each legal code byte stands for a 5-bit symbol. Eight symbols are joined into a 40-bit word, and that word leaves the block as five data bytes, one per clock. The stream is continuous: every run of eight accepted code bytes yields exactly five data bytes, and no symbol is split across two groups.

Two state machines do the work. The assembler has two states. It moves from `ASM_EMPTY` to `ASM_FILL` when it accepts the first symbol of a group. It returns from `ASM_FILL` to `ASM_EMPTY` when it accepts the eighth symbol, which hands the finished word to the drain, or when a restart arrives. A restart in `ASM_EMPTY` leaves it in `ASM_EMPTY`. The drain also has two states. It moves from `DRN_IDLE` to `DRN_SEND` when a finished word arrives, and at that point it presents the first byte and latches the word into a five-byte holding buffer. It moves from `DRN_SEND` back to `DRN_IDLE` after it presents the last byte. Because the word sits in the holding buffer, the assembler can keep accepting code bytes while earlier output is still going out.

A code byte outside the legal set of 32 marks its whole group as erroneous. It counts as symbol zero, so the group still completes and the byte count stays aligned. The restart input re-aligns the group boundary, and the first code byte after a restart becomes symbol 0 of a new group.

Top module: `gcr85_decoder`

## Requirements
- R1: While reset is asserted and after it is released, with no input, `out_valid` is 0 and `out_byte` and `out_err` are 0.
- R2: The legal codes are the following, each shown as symbol=code in hex. 00=AA 01=AB 02=AD 03=AE 04=AF 05=B5 06=B6 07=B7 08=BA 09=BB 0A=BD 0B=BE 0C=BF 0D=D5 0E=D6 0F=D7 10=DA 11=DB 12=DD 13=DE 14=DF 15=EA 16=EB 17=ED 18=EE 19=EF 1A=F5 1B=F6 1C=F7 1D=FA 1E=FB 1F=FD. Each legal code decodes to its symbol, and all of them have bit 7 set.
- R3: The first symbol of a group fills bits 39..35 of the 40-bit word and the eighth fills bits 4..0. The bytes leave in order from bits 39..32 down to bits 7..0.
- R4: The first data byte is valid in the cycle after the one that follows the clock edge accepting the eighth code byte. The other four follow on the next four consecutive cycles. Each group gives exactly five bytes.
- R5: Cycles with `code_valid` low are ignored whatever `code_byte` holds, so gaps of any length between code bytes do not change grouping or values.
- R6: A code byte that is not in the R2 set counts as symbol 0. It sets `out_err` on all five bytes of its group and on no other group.
- R7: A `restart` pulse discards the partial group. A code byte presented in the same cycle as `restart` is discarded too. The next accepted code byte is symbol 0 of a new group.
- R8: A `restart` has no effect on bytes already held for output. They are all still emitted with their values.
- R9: When `out_valid` is low, `out_byte` and `out_err` are 0.
- R10: Code bytes presented on every cycle produce back-to-back groups with no lost or repeated bytes, including while earlier bytes are still draining.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Group re-alignment pulse |
| code_valid | input | 1 | `code_byte` holds a code byte this cycle |
| code_byte | input | 8 | Group-coded byte from the read channel |
| out_valid | output | 1 | `out_byte` holds a decoded data byte |
| out_byte | output | 8 | Decoded data byte, most significant part of the word first |
| out_err | output | 1 | The group of this byte held an illegal code |

## Verification
The hardest situation to reach from the ports is a restart arriving while a finished group is still in the holding buffer and the next group is already being assembled. Only precise cycle alignment separates flushing the drain from clearing the assembler there. The stimulus sends a full group at line rate, pulses `restart` two edges after the eighth byte is accepted, and then starts a new group at once. The scoreboard must see all five bytes of the first group followed by the five bytes of the new one. A second hard case is a restart in the same cycle as a code byte, where a wrongly kept byte would shift every later symbol. The next group's values expose that shift.

// File: rtl/gcr85_pkg.sv
package gcr85_pkg;

    localparam int CODE_W = 8;
    localparam int SYM_W  = 5;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SYM_W-1:0]  sym_t;

    typedef enum logic {
        ASM_EMPTY,
        ASM_FILL
    } asm_state_e;

    typedef enum logic {
        DRN_IDLE,
        DRN_SEND
    } drn_state_e;

endpackage

// File: rtl/gcr85_symbol_lut.sv
module gcr85_symbol_lut
    import gcr85_pkg::*;
(
    input  code_t code,
    output sym_t  sym,
    output logic  legal
);

    always_comb begin
        legal = 1'b1;
        sym   = '0;
        case (code)
            8'hAA: sym = 5'h00;
            8'hAB: sym = 5'h01;
            8'hAD: sym = 5'h02;
            8'hAE: sym = 5'h03;
            8'hAF: sym = 5'h04;
            8'hB5: sym = 5'h05;
            8'hB6: sym = 5'h06;
            8'hB7: sym = 5'h07;
            8'hBA: sym = 5'h08;
            8'hBB: sym = 5'h09;
            8'hBD: sym = 5'h0A;
            8'hBE: sym = 5'h0B;
            8'hBF: sym = 5'h0C;
            8'hD5: sym = 5'h0D;
            8'hD6: sym = 5'h0E;
            8'hD7: sym = 5'h0F;
            8'hDA: sym = 5'h10;
            8'hDB: sym = 5'h11;
            8'hDD: sym = 5'h12;
            8'hDE: sym = 5'h13;
            8'hDF: sym = 5'h14;
            8'hEA: sym = 5'h15;
            8'hEB: sym = 5'h16;
            8'hED: sym = 5'h17;
            8'hEE: sym = 5'h18;
            8'hEF: sym = 5'h19;
            8'hF5: sym = 5'h1A;
            8'hF6: sym = 5'h1B;
            8'hF7: sym = 5'h1C;
            8'hFA: sym = 5'h1D;
            8'hFB: sym = 5'h1E;
            8'hFD: sym = 5'h1F;
            default: begin
                legal = 1'b0;
                sym   = '0;
            end
        endcase
    end

endmodule

// File: rtl/gcr85_assembler.sv
module gcr85_assembler
    import gcr85_pkg::*;
#(
    parameter  int SYMS   = 8,
    localparam int WORD_W = SYMS * SYM_W,
    localparam int CNT_W  = (SYMS > 1) ? $clog2(SYMS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    input  sym_t              sym,
    input  logic              legal,
    output logic              grp_valid,
    output logic [WORD_W-1:0] grp_word,
    output logic              grp_err
);

    asm_state_e        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] acc;
    logic              err_acc;

    logic              take;
    logic              last;
    logic [WORD_W-1:0] acc_nx;

    assign take   = in_valid && !restart;
    assign last   = (cnt == CNT_W'(SYMS - 1));
    assign acc_nx = {acc[WORD_W-SYM_W-1:0], sym};

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ASM_EMPTY: begin
                if (take) state_nx = ASM_FILL;
            end
            ASM_FILL: begin
                if (restart)          state_nx = ASM_EMPTY;
                else if (take && last) state_nx = ASM_EMPTY;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ASM_EMPTY;
        else        state <= state_nx;
    end

    // counter, accumulator and group hand-off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            acc       <= '0;
            err_acc   <= 1'b0;
            grp_valid <= 1'b0;
            grp_word  <= '0;
            grp_err   <= 1'b0;
        end else begin
            grp_valid <= 1'b0;
            if (restart) begin
                cnt     <= '0;
                acc     <= '0;
                err_acc <= 1'b0;
            end else if (take) begin
                if (last) begin
                    grp_valid <= 1'b1;
                    grp_word  <= acc_nx;
                    grp_err   <= err_acc | ~legal;
                    cnt       <= '0;
                    acc       <= '0;
                    err_acc   <= 1'b0;
                end else begin
                    cnt     <= cnt + 1'b1;
                    acc     <= acc_nx;
                    err_acc <= err_acc | ~legal;
                end
            end
        end
    end

    // R4
    last_symbol_hands_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last) |=> grp_valid);

    // R7
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && acc == '0 && state == ASM_EMPTY && !grp_valid));

    // R6
    illegal_marks_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !legal && last) |=> grp_err);

    // R7
    state_matches_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ASM_EMPTY) == (cnt == '0));

endmodule

// File: rtl/gcr85_drain.sv
module gcr85_drain
    import gcr85_pkg::*;
#(
    parameter  int BYTES  = 5,
    parameter  int BYTE_W = 8,
    localparam int WORD_W = BYTES * BYTE_W,
    localparam int IDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_valid,
    input  logic [WORD_W-1:0] grp_word,
    input  logic              grp_err,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_err
);

    drn_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] slot [BYTES];
    logic              err_hold;
    logic [BYTE_W-1:0] grp_bytes [BYTES];
    logic              at_end;

    // split the word, most significant byte in slot 0
    for (genvar i = 0; i < BYTES; i++) begin : g_split
        assign grp_bytes[i] = grp_word[(BYTES-1-i)*BYTE_W +: BYTE_W];
    end

    assign at_end = (idx == IDX_W'(BYTES - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            DRN_IDLE: if (grp_valid) state_nx = DRN_SEND;
            DRN_SEND: if (at_end)    state_nx = DRN_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DRN_IDLE;
        else        state <= state_nx;
    end

    // outputs and holding buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_err   <= 1'b0;
            idx       <= '0;
            err_hold  <= 1'b0;
            for (int i = 0; i < BYTES; i++) slot[i] <= '0;
        end else begin
            unique case (state)
                DRN_IDLE: begin
                    if (grp_valid) begin
                        out_valid <= 1'b1;
                        out_byte  <= grp_bytes[0];
                        out_err   <= grp_err;
                        err_hold  <= grp_err;
                        idx       <= IDX_W'(1);
                        for (int i = 0; i < BYTES; i++) slot[i] <= grp_bytes[i];
                    end else begin
                        out_valid <= 1'b0;
                        out_byte  <= '0;
                        out_err   <= 1'b0;
                    end
                end
                DRN_SEND: begin
                    out_valid <= 1'b1;
                    out_byte  <= slot[idx];
                    out_err   <= err_hold;
                    idx       <= at_end ? '0 : idx + 1'b1;
                end
            endcase
        end
    end

    // R10
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |-> (state == DRN_IDLE));

    // R4
    first_byte_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_valid |=> (out_valid && out_byte == $past(grp_word[WORD_W-1 -: BYTE_W])));

    // R6
    err_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DRN_SEND) |=> (out_valid && $stable(out_err)));

endmodule

// File: rtl/gcr85_decoder.sv
module gcr85_decoder
    import gcr85_pkg::*;
#(
    parameter  int SYMS_PER_GROUP = 8,
    parameter  int BYTE_W         = 8,
    localparam int WORD_W         = SYMS_PER_GROUP * SYM_W,
    localparam int OUT_BYTES      = WORD_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              code_valid,
    input  logic [7:0]        code_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_err
);

    sym_t              lut_sym;
    logic              lut_legal;
    logic              grp_valid;
    logic [WORD_W-1:0] grp_word;
    logic              grp_err;

    gcr85_symbol_lut u_lut (
        .code  (code_byte),
        .sym   (lut_sym),
        .legal (lut_legal)
    );

    gcr85_assembler #(
        .SYMS (SYMS_PER_GROUP)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .in_valid  (code_valid),
        .sym       (lut_sym),
        .legal     (lut_legal),
        .grp_valid (grp_valid),
        .grp_word  (grp_word),
        .grp_err   (grp_err)
    );

    gcr85_drain #(
        .BYTES  (OUT_BYTES),
        .BYTE_W (BYTE_W)
    ) u_drn (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_valid (grp_valid),
        .grp_word  (grp_word),
        .grp_err   (grp_err),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_err   (out_err)
    );

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_byte == '0 && !out_err));

    // R2
    legal_code_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && lut_legal) |-> code_byte[7]);

endmodule

// File: tb/sim_gcr85_decoder.sv
`timescale 1ns/1ps
module sim_gcr85_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       code_valid = 1'b0;
    logic [7:0] code_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_err;

    always #5 clk = ~clk;

    gcr85_decoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .code_valid (code_valid),
        .code_byte  (code_byte),
        .out_valid  (out_valid),
        .out_byte   (out_byte),
        .out_err    (out_err)
    );

    typedef struct {
        logic [7:0] b;
        logic       e;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   checks = 0;
    int   failures = 0;
    int   run_len = 0;
    bit   done = 1'b0;
    bit   mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // R2 encoding, written from the requirement
    function automatic logic [7:0] enc(input int s);
        case (s)
            0: return 8'hAA;  1: return 8'hAB;  2: return 8'hAD;  3: return 8'hAE;
            4: return 8'hAF;  5: return 8'hB5;  6: return 8'hB6;  7: return 8'hB7;
            8: return 8'hBA;  9: return 8'hBB; 10: return 8'hBD; 11: return 8'hBE;
           12: return 8'hBF; 13: return 8'hD5; 14: return 8'hD6; 15: return 8'hD7;
           16: return 8'hDA; 17: return 8'hDB; 18: return 8'hDD; 19: return 8'hDE;
           20: return 8'hDF; 21: return 8'hEA; 22: return 8'hEB; 23: return 8'hED;
           24: return 8'hEE; 25: return 8'hEF; 26: return 8'hF5; 27: return 8'hF6;
           28: return 8'hF7; 29: return 8'hFA; 30: return 8'hFB; default: return 8'hFD;
        endcase
    endfunction

    task automatic send_code(input logic [7:0] c);
        code_byte  = c;
        code_valid = 1'b1;
        @(posedge clk); #1;
        code_valid = 1'b0;
        code_byte  = 8'h13;
    endtask

    // driver: pushes the five expected bytes, then drives eight codes
    task automatic send_group(input int syms[8], input int bad_pos,
                              input logic [7:0] bad_code, input int gap,
                              input string tag);
        logic [39:0] word = '0;
        for (int i = 0; i < 8; i++) begin
            logic [4:0] sv = (i == bad_pos) ? 5'd0 : 5'(syms[i]);
            word = {word[34:0], sv};
        end
        for (int k = 0; k < 5; k++) begin
            exp_t it;
            it.b   = word[39-8*k -: 8];
            it.e   = (bad_pos >= 0);
            it.tag = tag;
            exp_q.push_back(it);
        end
        for (int i = 0; i < 8; i++) begin
            send_code((i == bad_pos) ? bad_code : enc(syms[i]));
            repeat (gap) begin
                @(posedge clk); #1;
            end
        end
    endtask

    // monitor and scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                run_len++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected byte", out_byte, 0);
                end else begin
                    cur = exp_q.pop_front();
                    chk(out_byte == cur.b, cur.tag, "byte", out_byte, cur.b);
                    chk(out_err == cur.e, "R6", "err flag", out_err, cur.e);
                end
            end else begin
                if (run_len != 0) chk(run_len == 5, "R4", "run length", run_len, 5);
                run_len = 0;
                chk(out_byte == 8'h00 && !out_err, "R9", "idle outputs",
                    {out_err, out_byte}, 0);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 during and after reset
        repeat (3) @(negedge clk);
        chk(!out_valid && out_byte == 0 && !out_err, "R1", "in reset",
            {out_valid, out_err, out_byte}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!out_valid && out_byte == 0 && !out_err, "R1", "after reset",
            {out_valid, out_err, out_byte}, 0);
        mon_on = 1'b1;
        @(posedge clk); #1;

        // R3 ordering and R4 latency
        send_group('{0, 1, 2, 3, 4, 5, 6, 7}, -1, 8'h00, 0, "R3");
        @(negedge clk);
        chk(out_valid == 1'b0, "R4", "too early", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R4", "first byte cycle", out_valid, 1);
        repeat (8) @(posedge clk);
        #1;

        // R2 and R10: all symbols, back-to-back at line rate
        send_group('{8, 9, 10, 11, 12, 13, 14, 15}, -1, 8'h00, 0, "R2");
        send_group('{16, 17, 18, 19, 20, 21, 22, 23}, -1, 8'h00, 0, "R10");
        send_group('{24, 25, 26, 27, 28, 29, 30, 31}, -1, 8'h00, 0, "R2");
        send_group('{31, 0, 31, 0, 31, 0, 31, 0}, -1, 8'h00, 0, "R10");

        // R5 gaps with garbage on the code bus
        send_group('{5, 26, 17, 9, 30, 2, 21, 12}, -1, 8'h00, 1, "R5");
        send_group('{19, 7, 28, 1, 14, 24, 3, 11}, -1, 8'h00, 3, "R5");

        // R6 illegal codes, then a clean group
        send_group('{1, 2, 3, 4, 5, 6, 7, 8}, 2, 8'h2A, 0, "R6");
        send_group('{31, 31, 31, 31, 31, 31, 31, 31}, 7, 8'hFF, 0, "R6");
        send_group('{9, 9, 9, 9, 9, 9, 9, 9}, 0, 8'h80, 0, "R6");
        send_group('{4, 8, 15, 16, 23, 22, 6, 10}, -1, 8'h00, 0, "R6");

        // R7 restart drops a partial group
        send_code(enc(3)); send_code(enc(7)); send_code(enc(11));
        restart = 1'b1;
        @(posedge clk); #1;
        restart = 1'b0;
        send_group('{20, 21, 22, 23, 24, 25, 26, 27}, -1, 8'h00, 0, "R7");

        // R7 byte alongside restart is discarded
        send_code(enc(13));
        restart    = 1'b1;
        code_valid = 1'b1;
        code_byte  = enc(9);
        @(posedge clk); #1;
        restart    = 1'b0;
        code_valid = 1'b0;
        send_group('{2, 4, 6, 8, 10, 12, 14, 16}, -1, 8'h00, 0, "R7");

        // R8 restart while bytes drain, next group starts at once
        send_group('{30, 29, 28, 27, 26, 25, 24, 23}, -1, 8'h00, 0, "R8");
        @(posedge clk); #1;
        restart = 1'b1;
        @(posedge clk); #1;
        restart = 1'b0;
        send_group('{1, 3, 5, 7, 9, 11, 13, 15}, -1, 8'h00, 0, "R8");

        repeat (20) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R4", "missing bytes", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule